// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit linear address into a physical address through one level of paging that lives in memory. A requester hands it a linear address while a process-table register input supplies the base of the active page table. On acceptance the block latches both values. It then fetches exactly one 32-bit entry over a valid/ready read port and returns either a translated physical address or a page-fault indication.

The page number is the upper 20 bits of the linear address, and the byte offset within the 4 KiB page is the lower 12 bits. The entry word sits at the table base plus four times the page number. Each entry carries a present flag and a 20-bit frame number. The frame number joined to the untouched offset forms the physical address. A different table base gives each process its own mapping. Several linear addresses, within one table or across tables, may point at the same frame, and the block treats such aliases like any other mapping.

The response stays on the output until the requester takes it. Only then does the block go back to idle and take the next request.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: reqReady is 1, rspValid is 0 and memReqValid is 0.
- R2: A request is taken only when reqValid and reqReady are both 1 at a clock edge. reqReady stays 0 from acceptance until the response has been accepted.
- R3: The entry read address is the table base with its low 12 bits forced to zero, plus the page number (linear address bits 31:12) times 4. memReqValid and memReqAddr hold steady until memReqReady is seen.
- R4: When the entry's present flag (bit 0) is 1, rspPhysAddr equals entry bits 31:12 followed by linear address bits 11:0, with rspFault 0 and rspFaultAddr 0.
- R5: When the present flag is 0, rspFault is 1, rspFaultAddr equals the requested linear address, and rspPhysAddr is 0.
- R6: Entry bits 11:1 are reserved. Their value has no effect on the response.
- R7: While rspValid is 1 and rspReady is 0, rspValid and all response fields stay unchanged.
- R8: The table base and linear address are captured at acceptance. The same linear address under two different bases uses two different entries. Changing the inputs after acceptance does not alter the walk in progress.
- R9: Two linear addresses that map to the same frame both translate without a fault.
- R10: Each accepted request causes exactly one memory read handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqLinAddr | input | 32 | Linear address to translate |
| tableBase | input | 32 | Page table base of the current process |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory takes the read |
| memReqAddr | output | 32 | Byte address of the entry word |
| memRspValid | input | 1 | Entry data returned |
| memRspData | input | 32 | Entry word |
| rspValid | output | 1 | Translation result present |
| rspReady | input | 1 | Requester takes the result |
| rspPhysAddr | output | 32 | Physical address (0 on fault) |
| rspFault | output | 1 | Page not present |
| rspFaultAddr | output | 32 | Faulting linear address (0 when no fault) |

## Verification
The assertions check several properties on every cycle. They check that the block is never ready while a read or a response is outstanding. They check that a stalled read request and a stalled response keep their values. They check that one read handshake is never followed by a second for the same walk, and that a faulting response never carries a physical address. Other behaviours can only be shown by the bench scenarios, because they depend on memory contents and expected mappings. These are the entry address arithmetic with an unaligned base, frame and offset concatenation, ignoring of reserved bits, per-process tables, aliasing, and the latching of inputs when they change mid-walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic captureEntry;
  } walkStrobe_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        rspValid,
  input  logic        rspReady,
  output walkStrobe_t strobe
);

  walkState_e state;
  logic       issued;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          issued <= 1'b0;
          if (reqValid) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (memReqValid && memReqReady) issued <= 1'b1;
          if (issued && memRspValid) state <= ST_RESP;
        end
        ST_RESP: begin
          if (rspReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady            = (state == ST_IDLE);
    memReqValid         = (state == ST_WAIT) && !issued;
    rspValid            = (state == ST_RESP);
    strobe.captureReq   = (state == ST_IDLE) && reqValid;
    strobe.captureEntry = (state == ST_WAIT) && issued && memRspValid;
  end

  // R10: after a read handshake no further read is raised for this walk
  a_r10_single_read: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  // R2: an accepted request leaves the idle state on the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int PTE_W       = 32,
  parameter int PRESENT_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqLinAddr,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [PTE_W-1:0]  memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] physAddr,
  output logic              fault,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam int PN_W   = ADDR_W - OFF_W;
  localparam int IDX_SH = $clog2(PTE_W / 8);
  localparam logic [ADDR_W-1:0] BASE_MASK    = {{PN_W{1'b1}}, {OFF_W{1'b0}}};
  localparam logic [PTE_W-1:0]  PRESENT_MASK = PTE_W'(1) << PRESENT_BIT;

  logic [ADDR_W-1:0] linReg;
  logic [PN_W-1:0]   baseFrame;
  logic [PN_W-1:0]   frameReg;
  logic              presentReg;
  logic [PN_W-1:0]   pageNum;

  assign pageNum = linReg[ADDR_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linReg     <= '0;
      baseFrame  <= '0;
      frameReg   <= '0;
      presentReg <= 1'b0;
    end else begin
      if (strobe.captureReq) begin
        linReg    <= reqLinAddr;
        baseFrame <= PN_W'((tableBase & BASE_MASK) >> OFF_W);
      end
      if (strobe.captureEntry) begin
        frameReg   <= memRspData[PTE_W-1 -: PN_W];
        presentReg <= |(memRspData & PRESENT_MASK);
      end
    end
  end

  always_comb begin
    memReqAddr = {baseFrame, {OFF_W{1'b0}}} + ADDR_W'({pageNum, {IDX_SH{1'b0}}});
    fault      = !presentReg;
    physAddr   = fault ? '0 : {frameReg, linReg[OFF_W-1:0]};
    faultAddr  = fault ? linReg : '0;
  end

  // R8: the captured request is not disturbed by input changes while busy
  a_r8_lin_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureReq |=> $stable(linReg));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int PTE_W       = 32,
  parameter int PRESENT_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqLinAddr,
  input  logic [ADDR_W-1:0] tableBase,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic              rspFault,
  output logic [ADDR_W-1:0] rspFaultAddr
);

  walkStrobe_t strobe;
  logic        rawFault;

  pt_walker_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .rspValid   (rspValid),
    .rspReady   (rspReady),
    .strobe     (strobe)
  );

  pt_walker_dp #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .PTE_W      (PTE_W),
    .PRESENT_BIT(PRESENT_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqLinAddr(reqLinAddr),
    .tableBase (tableBase),
    .memRspData(memRspData),
    .memReqAddr(memReqAddr),
    .physAddr  (rspPhysAddr),
    .fault     (rawFault),
    .faultAddr (rspFaultAddr)
  );

  assign rspFault = rspValid && rawFault;

  // R2: never ready while a read or a result is outstanding
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || rspValid) |-> !reqReady);

  // R3: a stalled read keeps its request and address
  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R7: a stalled response keeps every field
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspPhysAddr)
      && $stable(rspFault) && $stable(rspFaultAddr)));

  // R5: a faulting response carries no physical address
  a_r5_fault_no_phys: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspPhysAddr == '0));

  // R4: a good translation reports no faulting address
  a_r4_ok_no_fault_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspFaultAddr == '0));

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqLinAddr = '0;
  logic [31:0] tableBase = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [31:0] rspPhysAddr;
  logic        rspFault;
  logic [31:0] rspFaultAddr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqLinAddr(reqLinAddr), .tableBase(tableBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady),
    .rspPhysAddr(rspPhysAddr), .rspFault(rspFault), .rspFaultAddr(rspFaultAddr)
  );

  // behavioural page-table memory, 16 KiB, word indexed
  logic [31:0] mem [0:4095];
  logic [31:0] lastAddr = '0;
  int          readCount = 0;
  logic        pend = 1'b0;
  int          pendDelay = 0;
  int          memLat = 0;
  logic        memRspValidR = 1'b0;
  logic [31:0] memRspDataR = '0;
  assign memRspValid = memRspValidR;
  assign memRspData  = memRspDataR;

  always @(posedge clk) begin
    if (!rstN) begin
      pend <= 1'b0;
      memRspValidR <= 1'b0;
    end else begin
      memRspValidR <= 1'b0;
      if (memReqValid && memReqReady) begin
        lastAddr  <= memReqAddr;
        readCount <= readCount + 1;
        pendDelay <= memLat;
        pend      <= 1'b1;
      end else if (pend) begin
        if (pendDelay == 0) begin
          memRspValidR <= 1'b1;
          memRspDataR  <= mem[lastAddr[13:2]];
          pend         <= 1'b0;
        end else begin
          pendDelay <= pendDelay - 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int widx(input logic [31:0] base, input logic [19:0] pn);
    return int'(((base & 32'hFFFF_F000) + {10'd0, pn, 2'b00}) >> 2);
  endfunction

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] lin;
    logic        fault;
    logic [31:0] phys;
    logic [7:0]  hold;
    logic [7:0]  stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 32'h0000_2ABC, 1'b0, 32'h0000_3ABC, 8'd0, 8'd0}, // R4 R9
    '{32'h0000_2000, 32'h0000_4123, 1'b0, 32'h0000_3123, 8'd3, 8'd0}, // R6 R9 alias
    '{32'h0000_1000, 32'h0000_3FFF, 1'b0, 32'h0000_5FFF, 8'd0, 8'd4}, // R4
    '{32'h0000_2000, 32'h0000_3000, 1'b0, 32'h0007_7000, 8'd2, 8'd2}, // R8
    '{32'h0000_1000, 32'h0000_7456, 1'b1, 32'h0000_0000, 8'd2, 8'd0}, // R5
    '{32'h0000_2000, 32'h0000_8001, 1'b1, 32'h0000_0000, 8'd0, 8'd1}, // R6 R5
    '{32'h0000_1FFF, 32'h0000_0777, 1'b0, 32'h1234_5777, 8'd1, 8'd0}, // R3
    '{32'h0000_2000, 32'h0000_9ABC, 1'b1, 32'h0000_0000, 8'd0, 8'd0}  // R5 empty
  };

  task automatic walk(input vec_t v);
    logic [31:0] expAddr;
    int          rc0;
    expAddr = (v.base & 32'hFFFF_F000) + {10'd0, v.lin[31:12], 2'b00};
    rc0 = readCount;
    memReqReady = (v.stall == 0);
    @(negedge clk);
    reqValid = 1'b1; tableBase = v.base; reqLinAddr = v.lin;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    tableBase = ~v.base;           // R8: changes after acceptance must not matter
    reqLinAddr = 32'hDEAD_BEEF;
    for (int i = 0; i < int'(v.stall); i++) begin
      chk("R2 busy not ready", {31'd0, reqReady}, 32'd0);
      chk("R3 read held", {31'd0, memReqValid}, 32'd1);
      chk("R3 entry address", memReqAddr, expAddr);
      @(negedge clk);
    end
    memReqReady = 1'b1;
    while (!rspValid) @(negedge clk);
    chk("R3 entry address read", lastAddr, expAddr);
    chk("R10 one read", readCount - rc0, 1);
    chk("R2 not ready at response", {31'd0, reqReady}, 32'd0);
    chk(v.fault ? "R5 fault flag" : "R4 fault flag", {31'd0, rspFault}, {31'd0, v.fault});
    chk(v.fault ? "R5 phys zero" : "R4 phys", rspPhysAddr, v.phys);
    chk(v.fault ? "R5 fault addr" : "R4 fault addr zero", rspFaultAddr, v.fault ? v.lin : 32'd0);
    for (int i = 0; i < int'(v.hold); i++) begin
      @(negedge clk);
      chk("R7 held valid", {31'd0, rspValid}, 32'd1);
      chk("R7 held phys", rspPhysAddr, v.phys);
      chk("R7 held fault", {31'd0, rspFault}, {31'd0, v.fault});
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk("R7 released", {31'd0, rspValid}, 32'd0);
    chk("R2 idle again", {31'd0, reqReady}, 32'd1);
    chk("R10 no extra read", readCount - rc0, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[widx(32'h1000, 20'h00002)] = 32'h0000_3001;
    mem[widx(32'h2000, 20'h00004)] = 32'h0000_3FFF; // reserved bits set
    mem[widx(32'h1000, 20'h00003)] = 32'h0000_5001;
    mem[widx(32'h2000, 20'h00003)] = 32'h0007_7001;
    mem[widx(32'h1000, 20'h00007)] = 32'hABCD_E000;
    mem[widx(32'h2000, 20'h00008)] = 32'hABCD_EFFE; // reserved set, not present
    mem[widx(32'h1000, 20'h00000)] = 32'h1234_5001;

    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, reqReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'd0, reqReady}, 32'd1);
    chk("R1 no response", {31'd0, rspValid}, 32'd0);
    chk("R1 no read", {31'd0, memReqValid}, 32'd0);

    memLat = 0;
    for (int k = 0; k < NV; k++) begin
      memLat = k % 3;
      walk(VECS[k]);
    end

    // R8: same linear address, two process tables, back to back
    walk('{32'h0000_1000, 32'h0000_3010, 1'b0, 32'h0000_5010, 8'd0, 8'd0});
    walk('{32'h0000_2000, 32'h0000_3010, 1'b0, 32'h0007_7010, 8'd0, 8'd0});

    // R6: reserved-bit-only difference from a clean entry gives the same frame
    mem[widx(32'h1000, 20'h00005)] = 32'h0000_3AA1;
    walk('{32'h0000_1000, 32'h0000_5F00, 1'b0, 32'h0000_3F00, 8'd1, 8'd0});

    // R2: reqValid held while busy is not taken twice
    @(negedge clk);
    reqValid = 1'b1; tableBase = 32'h1000; reqLinAddr = 32'h0000_2004;
    @(negedge clk);
    while (!rspValid) @(negedge clk);
    chk("R2 held request one read", {31'd0, reqReady}, 32'd0);
    reqValid = 1'b0;
    chk("R9 phys", rspPhysAddr, 32'h0000_3004);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 no second walk", {31'd0, memReqValid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule